// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable, cycle-level stand-in for an asynchronous static memory that has a 16-bit word split into two independently selectable bytes. Its active-low control pins are a chip enable, an output enable, a write enable and a select for each byte lane. From these pins the block works out, for each lane on its own, whether the lane is deselected, idle, reading or writing.

Real tri-state data pins are replaced by a read data bus and one drive flag per lane. A lane's bits on the read bus are only meaningful while its drive flag is high, and they are forced to zero otherwise. Writes are committed on the rising clock edge in any cycle where the write condition holds, and only for the selected lanes. Reads are purely combinational from the current address.

The block is meant to be the memory target in a testbench for a memory controller. The full-size array is obtained with `ADDR_W = 16` (65,536 words). The default is kept smaller so that elaboration stays light.

Top module: `byte_lane_sram`

## Requirements
- R1: While `ce_n` is 1, both drive flags are 0, `rd_data` is all zeros, and a rising edge changes no stored word, whatever the other controls are.
- R2: With `ce_n` = 0, `we_n` = 1 and `oe_n` = 1, neither lane is driven.
- R3: With both `lo_sel_n` and `hi_sel_n` at 1, neither lane is driven and a rising edge stores nothing, even with `we_n` = 0.
- R4: With `ce_n` = 0, `we_n` = 1 and `oe_n` = 0, a lane whose select is 0 raises its drive flag and shows its stored byte. A lane whose select is 1 stays undriven.
- R5: The bits of `rd_data` that belong to an undriven lane read as 0. Bits 7:0 belong to the lower lane (`oe_lo`) and bits 15:8 to the upper lane (`oe_hi`).
- R6: With `ce_n` = 0 and `we_n` = 0, each rising edge stores `wr_data[7:0]` if `lo_sel_n` = 0 and `wr_data[15:8]` if `hi_sel_n` = 0, whatever `oe_n` is. An unselected lane keeps its old byte. Writing stops as soon as any one of the chip enable, the write enable, or both selects goes inactive.
- R7: Write takes priority over output enable: while `ce_n` = 0 and `we_n` = 0, no lane is driven, even with `oe_n` = 0.
- R8: Read data follows `addr` in the same cycle, with no pipeline register. A word written at an edge can be read right after that edge.
- R9: While `rst` is 1, no rising edge changes any stored word.
- R10: The array holds 2^ADDR_W independent words. A write to one address leaves every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to commit writes |
| rst | input | 1 | Synchronous active-high reset; blocks writes while high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lo_sel_n | input | 1 | Lower byte lane select (bits 7:0), active low |
| hi_sel_n | input | 1 | Upper byte lane select (bits 15:8), active low |
| addr | input | ADDR_W | Word address |
| wr_data | input | 2*LANE_W | Write data, lower lane in the low byte |
| rd_data | output | 2*LANE_W | Read data; zero in lanes that are not driven |
| oe_lo | output | 1 | Lower lane drive flag |
| oe_hi | output | 1 | Upper lane drive flag |

## Verification
The bench builds the block with `ADDR_W = 6` and `LANE_W = 8`, which gives a 64-word array. At that size every word can be filled with an arithmetic pattern and read back, so any address aliasing or cross-word disturbance shows up. All 32 combinations of the five control pins are driven, each one at its own address with fresh data. For every combination the bench compares the drive flags and lane data inside the cycle, and reads the word back after the edge to confirm what was and was not committed. Lane-controlled back-to-back writes with the write enable held low, and a write attempted during reset, cover the remaining ways a write can start and stop.

// File: rtl/blm_pkg.sv
package blm_pkg;

    localparam int LANE_COUNT = 2;

    typedef enum logic [1:0] {
        LANE_OFF   = 2'd0,
        LANE_QUIET = 2'd1,
        LANE_READ  = 2'd2,
        LANE_WRITE = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } ctrl_pins_t;

    // Per-lane decode; write outranks output enable.
    function automatic lane_mode_e lane_mode(ctrl_pins_t c, logic sel_n);
        lane_mode_e m;
        if (c.ce_n)
            m = LANE_OFF;
        else if (sel_n)
            m = LANE_QUIET;
        else if (!c.we_n)
            m = LANE_WRITE;
        else if (!c.oe_n)
            m = LANE_READ;
        else
            m = LANE_QUIET;
        return m;
    endfunction

endpackage

// File: rtl/blm_ctrl_decode.sv
module blm_ctrl_decode
    import blm_pkg::*;
(
    input  logic                  rst,
    input  ctrl_pins_t            pins,
    input  logic [LANE_COUNT-1:0] sel_n,
    output logic [LANE_COUNT-1:0] commit,
    output logic [LANE_COUNT-1:0] drive
);

    lane_mode_e modes [LANE_COUNT];

    for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
        always_comb begin
            modes[g]  = lane_mode(pins, sel_n[g]);
            commit[g] = (modes[g] == LANE_WRITE) && !rst;
            drive[g]  = (modes[g] == LANE_READ);
        end
    end

endmodule

// File: rtl/blm_lane_store.sv
module blm_lane_store #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (commit)
            cells[addr] <= wdata;
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/blm_out_stage.sv
module blm_out_stage #(
    parameter int LANE_W = 8
) (
    input  logic              drive,
    input  logic [LANE_W-1:0] raw,
    output logic [LANE_W-1:0] shown
);

    assign shown = drive ? raw : '0;

endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
    import blm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ce_n,
    input  logic                         oe_n,
    input  logic                         we_n,
    input  logic                         lo_sel_n,
    input  logic                         hi_sel_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [LANE_COUNT*LANE_W-1:0] wr_data,
    output logic [LANE_COUNT*LANE_W-1:0] rd_data,
    output logic                         oe_lo,
    output logic                         oe_hi
);

    ctrl_pins_t            pins;
    logic [LANE_COUNT-1:0] sel_n;
    logic [LANE_COUNT-1:0] commit;
    logic [LANE_COUNT-1:0] drive;

    assign pins  = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};
    assign sel_n = {hi_sel_n, lo_sel_n};

    blm_ctrl_decode u_decode (
        .rst    (rst),
        .pins   (pins),
        .sel_n  (sel_n),
        .commit (commit),
        .drive  (drive)
    );

    for (genvar g = 0; g < LANE_COUNT; g++) begin : g_lane
        logic [LANE_W-1:0] raw;

        blm_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
            .clk    (clk),
            .commit (commit[g]),
            .addr   (addr),
            .wdata  (wr_data[g*LANE_W +: LANE_W]),
            .rdata  (raw)
        );

        blm_out_stage #(.LANE_W(LANE_W)) u_out (
            .drive (drive[g]),
            .raw   (raw),
            .shown (rd_data[g*LANE_W +: LANE_W])
        );
    end

    assign oe_lo = drive[0];
    assign oe_hi = drive[1];

endmodule

// File: rtl/blm_checker.sv
module blm_checker #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                ce_n,
    input logic                oe_n,
    input logic                we_n,
    input logic                lo_sel_n,
    input logic                hi_sel_n,
    input logic [ADDR_W-1:0]   addr,
    input logic [2*LANE_W-1:0] wr_data,
    input logic [2*LANE_W-1:0] rd_data,
    input logic                oe_lo,
    input logic                oe_hi
);

    assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> (!oe_lo && !oe_hi && rd_data == '0));

    assert_outputs_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && we_n && oe_n) |-> (!oe_lo && !oe_hi));

    assert_no_lane_R3: assert property (@(posedge clk) disable iff (rst)
        (lo_sel_n && hi_sel_n) |-> (!oe_lo && !oe_hi));

    assert_read_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && we_n && !oe_n) |-> ((oe_lo == !lo_sel_n) && (oe_hi == !hi_sel_n)));

    assert_lo_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !oe_lo |-> (rd_data[LANE_W-1:0] == '0));

    assert_hi_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !oe_hi |-> (rd_data[2*LANE_W-1:LANE_W] == '0));

    assert_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!ce_n && !we_n && !lo_sel_n) && $stable(addr)
         && !ce_n && we_n && !oe_n && !lo_sel_n)
        |-> (rd_data[LANE_W-1:0] == $past(wr_data[LANE_W-1:0])));

    assert_write_first_R7: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !we_n) |-> (!oe_lo && !oe_hi));

endmodule

bind byte_lane_sram blm_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .lo_sel_n (lo_sel_n),
    .hi_sel_n (hi_sel_n),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .oe_lo    (oe_lo),
    .oe_hi    (oe_hi)
);

// File: tb/byte_lane_sram_bench.sv
module byte_lane_sram_bench;

    localparam int AW    = 6;
    localparam int LW    = 8;
    localparam int DW    = 2 * LW;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic          lo_sel_n = 1'b1, hi_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          oe_lo, oe_hi;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [WORDS];

    byte_lane_sram #(.ADDR_W(AW), .LANE_W(LW)) u_byte_lane_sram (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .lo_sel_n(lo_sel_n), .hi_sel_n(hi_sel_n), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .oe_lo(oe_lo), .oe_hi(oe_hi)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 40503 + 4660);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply pins at a negedge, check comb outputs, commit at posedge, update model.
    task automatic step(string tag, logic c, logic o, logic w, logic l, logic h,
                        int a, logic [DW-1:0] d);
        logic rd, dl, dh;
        logic [DW-1:0] exp;
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; lo_sel_n = l; hi_sel_n = h;
        addr = AW'(a); wr_data = d;
        #2;
        rd  = !c && w && !o;
        dl  = rd && !l;
        dh  = rd && !h;
        exp = {dh ? model[a][DW-1:LW] : LW'(0), dl ? model[a][LW-1:0] : LW'(0)};
        chk({tag, " flags"}, {30'd0, oe_hi, oe_lo}, {30'd0, dh, dl});
        chk({tag, " data R5"}, 32'(rd_data), 32'(exp));
        @(posedge clk);
        if (!rst && !c && !w) begin
            if (!l) model[a][LW-1:0]  = d[LW-1:0];
            if (!h) model[a][DW-1:LW] = d[DW-1:LW];
        end
    endtask

    // Full-word read of one address, checked inside the cycle (no edge needed).
    task automatic rdchk(string tag, int a);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; lo_sel_n = 1'b0; hi_sel_n = 1'b0;
        addr = AW'(a);
        #1;
        chk({tag, " R4 flags"}, {30'd0, oe_hi, oe_lo}, 32'd3);
        chk({tag, " R8 R10 word"}, 32'(rd_data), 32'(model[a]));
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state with the chip deselected
        chk("R1 reset flags", {30'd0, oe_hi, oe_lo}, 32'd0);
        chk("R1 reset data", 32'(rd_data), 32'd0);
        rst = 1'b0;

        // Fill every word with full-width writes (R6), oe low to show it is ignored
        for (int a = 0; a < WORDS; a++)
            step("R6 R7 fill", 1'b0, a[0], 1'b0, 1'b0, 1'b0, a, pat(a));
        @(negedge clk);
        for (int a = 0; a < WORDS; a++) begin
            rdchk("fill readback", a);
            #1;
        end

        // R9: write attempted during reset must not land
        @(negedge clk);
        rst = 1'b1;
        step("R9 write in reset", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7, ~pat(7));
        @(negedge clk);
        rst = 1'b0;
        rdchk("R9 after reset", 7);

        // Sweep all control combinations, each at its own address
        for (int c = 0; c < 32; c++) begin
            string tag;
            logic bc, bo, bw, bl, bh;
            {bc, bo, bw, bl, bh} = 5'(c);
            if (bc)              tag = "R1 sweep";
            else if (bl && bh)   tag = "R3 sweep";
            else if (!bw)        tag = "R7 R6 sweep";
            else if (bo)         tag = "R2 sweep";
            else                 tag = "R4 sweep";
            step(tag, bc, bo, bw, bl, bh, c, ~pat(c) ^ DW'(c * 257));
            @(negedge clk);
            rdchk({tag, " readback"}, c);
            #1;
            rdchk({tag, " neighbour"}, c ^ 1);
        end

        // Back-to-back lane-controlled writes with write enable held low
        for (int k = 0; k < 8; k++)
            step("R6 lane walk", 1'b0, 1'b1, 1'b0, k[0], !k[0], 40 + k, DW'(16'hA50F + k * 4369));
        // Write ends when both selects rise though we_n stays low (R3)
        step("R3 selects off", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 44, 16'hFFFF);
        // Write ends when chip enable rises (R1)
        step("R1 chip off", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 45, 16'h0000);
        @(negedge clk);
        for (int a = 0; a < WORDS; a++) begin
            rdchk("final R10", a);
            #1;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule